// File: doc/BRIEF.md
# Shadowed Register Access Sequencer

This block is a host-side bus master for a dual-channel serial controller that exposes its sixteen write and sixteen read registers through an indirect pointer scheme. A client presents one logical request: an operation, a register index, a channel and a data byte. The sequencer turns it into the peripheral bus cycles needed. Most registers need a pointer write followed by a data access on the control port. A few registers use one direct access. Every bus cycle within a request is followed by a fixed recovery gap of system clocks before the next one.

Because most controller registers cannot be read back, the sequencer keeps a per-channel copy of every write register. It keeps one shared copy for the master interrupt register, which both channels share. Read-backs are answered from these copies with no bus traffic. When a write targets the sync-character register or its alternate option register, the sequencer rewrites the selector bit in register 15 first if that bit is in the wrong state. Reads of the interrupt-pending register go to channel A, and reads of the status-modified vector go to channel B, whichever channel was requested.

Request encoding: `req_op` 0 = write a write register, 1 = read a read register, 2 = read back a write register from its copy, 3 = reserved. `req_idx` 0..15 is the register number. Index 16 names the alternate option register (written through pointer 7). Channel A is 0 and channel B is 1.

Top module: `regseq_top`

## Requirements
- R1: Within one request, two consecutive bus strobes (`bus_stb`, one cycle each) are separated by exactly GAP_CLKS idle cycles.
- R2: A write to index 1..6, 10..13 or 15 issues a control-port write of the index (pointer), then a control-port write of the data. A read of index 1, 6, 7 or 10 issues the pointer write and then a control-port read. Both go on the requested channel. The response byte is the one sampled on `bus_rdata` during the read strobe.
- R3: Index 0 uses a single control-port access and index 8 uses a single data-port access (`bus_sel_data`=1), for both write and read, with no pointer phase.
- R4: A write to index 7 first rewrites register 15 with bit 0 cleared (pointer 15, then the copy of register 15 with bit 0 = 0), but only if the channel's copy of register 15 has bit 0 set. The pointer/data write of 7 follows. The copy is updated.
- R5: A write to index 16 first rewrites register 15 with bit 0 set if that bit is clear, then writes pointer 7 and the data. The value is read back through op 2 index 16.
- R6: A write to index 9 is sent unchanged but kept as data & 0x3F in one copy shared by both channels. A write to index 14 is sent unchanged but kept as data & 0x1F.
- R7: Op 2 for index 1..7, 9..16 returns the channel's stored copy with `rsp_valid` in the cycle after acceptance and no bus strobe. The copies of channel A and B are independent.
- R8: A read of index 3 is issued on channel A and a read of index 2 on channel B, whatever `req_chan` says.
- R9: `busy` is high from the cycle after acceptance until the response. `rsp_valid` comes GAP_CLKS+1 cycles after the last strobe, or 1 cycle after it when `req_nogap` was set.
- R10: Op 3, a write with index above 16, a read of an index outside {0,1,2,3,6,7,8,10}, and op 2 of index 0, 8 or above 16 all pulse `rsp_err` for one cycle with no bus strobe.
- R11: After reset `busy`, `bus_stb`, `rsp_valid` and `rsp_err` are low and every stored register copy reads back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; accepted when `busy` is low |
| req_op | input | 2 | Operation code |
| req_idx | input | 5 | Register index, 16 = alternate option register |
| req_chan | input | 1 | Channel, 0 = A, 1 = B |
| req_data | input | 8 | Write data |
| req_nogap | input | 1 | Skip the recovery gap after the last bus cycle |
| busy | output | 1 | Bus sequence in progress |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_data | output | 8 | Read result, valid with `rsp_valid` |
| rsp_err | output | 1 | One-cycle pulse for an unsupported request |
| bus_stb | output | 1 | One-cycle peripheral access strobe |
| bus_sel_data | output | 1 | 0 = control port, 1 = data port |
| bus_wr | output | 1 | 1 = write, 0 = read |
| bus_chan | output | 1 | Channel addressed |
| bus_wdata | output | 8 | Write byte |
| bus_rdata | input | 8 | Read byte, sampled at the end of a read strobe |

## Verification
The bench toggles the register 15 selector through alternating writes of index 7 and index 16. A design that tests the wrong polarity, or forgets to update its copy, either skips the reselection or issues it on every write. It writes the masked registers with all ones and reads them back from the other channel. This exposes a design that stores the command bits or keeps per-channel copies of the shared register. It also requests the interrupt-pending and vector reads on the wrong channel, and checks gap and completion timing with and without `req_nogap`, where an off-by-one counter would shift every strobe.

// File: rtl/regseq_pkg.sv
package regseq_pkg;
  localparam int DW      = 8;
  localparam int NREG    = 16;
  localparam int MAXACC  = 4;
  localparam int IDXW    = 5;
  localparam logic [IDXW-1:0] IDX_OPT = 5'd16;

  typedef enum logic [1:0] {
    OP_WRITE  = 2'd0,
    OP_READ   = 2'd1,
    OP_SHADOW = 2'd2,
    OP_RSVD   = 2'd3
  } op_e;

  typedef struct packed {
    logic          sel_data;
    logic          wr;
    logic          chan;
    logic [DW-1:0] val;
  } acc_t;
endpackage

// File: rtl/regseq_shadow.sv
module regseq_shadow #(
  parameter int NCH      = 2,
  parameter int NREG     = 16,
  parameter int DW       = 8,
  parameter int SEL_SLOT = 15
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic                    we_common,
  input  logic                    wchan,
  input  logic [$clog2(NREG)-1:0] wslot,
  input  logic [DW-1:0]           wdata,
  input  logic                    we_sel,
  input  logic [DW-1:0]           wsel_data,
  input  logic                    rchan,
  input  logic [$clog2(NREG)-1:0] rslot,
  input  logic                    rcommon,
  output logic [DW-1:0]           rdata,
  output logic [DW-1:0]           sel_q
);
  localparam int SW = $clog2(NREG);
  localparam int DEPTH = NCH * NREG;
  localparam logic [SW-1:0] SELS = SW'(SEL_SLOT);

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] common_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      common_q <= '0;
    end else begin
      if (we && !we_common) mem[{wchan, wslot}] <= wdata;
      if (we && we_common)  common_q <= wdata;
      if (we_sel)           mem[{wchan, SELS}] <= wsel_data;
    end
  end

  assign rdata = rcommon ? common_q : mem[{rchan, rslot}];
  assign sel_q = mem[{rchan, SELS}];
endmodule

// File: rtl/regseq_decode.sv
module regseq_decode
  import regseq_pkg::*;
(
  input  logic [1:0]      op,
  input  logic [IDXW-1:0] idx,
  input  logic            chan,
  input  logic [DW-1:0]   data,
  input  logic [DW-1:0]   sel_q,
  input  logic [DW-1:0]   copy_val,
  output logic            rb_common,
  output logic [3:0]      rb_slot,
  output logic [2:0]      n_acc,
  output acc_t [MAXACC-1:0] acc,
  output logic            is_local,
  output logic            is_err,
  output logic [DW-1:0]   lval,
  output logic            sw_en,
  output logic            sw_common,
  output logic [3:0]      sw_slot,
  output logic [DW-1:0]   sw_val,
  output logic            s15_en,
  output logic [DW-1:0]   s15_val
);
  function automatic acc_t mk(logic sd, logic w, logic c, logic [DW-1:0] v);
    acc_t a;
    a.sel_data = sd; a.wr = w; a.chan = c; a.val = v;
    return a;
  endfunction

  assign rb_common = (idx == 5'd9);
  assign rb_slot   = (idx == IDX_OPT) ? 4'd8 : idx[3:0];
  assign lval      = copy_val;

  always_comb begin
    n_acc = '0;
    for (int k = 0; k < MAXACC; k++) acc[k] = '0;
    is_local = 1'b0; is_err = 1'b0;
    sw_en = 1'b0; sw_common = 1'b0; sw_slot = idx[3:0]; sw_val = data;
    s15_en = 1'b0; s15_val = sel_q;
    case (op_e'(op))
      OP_WRITE: begin
        if (idx == 5'd0) begin
          n_acc = 3'd1; acc[0] = mk(1'b0, 1'b1, chan, data);
        end else if (idx == 5'd8) begin
          n_acc = 3'd1; acc[0] = mk(1'b1, 1'b1, chan, data);
        end else if (idx == 5'd7 || idx == IDX_OPT) begin
          sw_en   = 1'b1;
          sw_slot = (idx == IDX_OPT) ? 4'd8 : 4'd7;
          if (sel_q[0] != (idx == IDX_OPT)) begin
            s15_en  = 1'b1;
            s15_val = {sel_q[DW-1:1], idx == IDX_OPT};
            acc[0]  = mk(1'b0, 1'b1, chan, 8'd15);
            acc[1]  = mk(1'b0, 1'b1, chan, {sel_q[DW-1:1], idx == IDX_OPT});
            acc[2]  = mk(1'b0, 1'b1, chan, 8'd7);
            acc[3]  = mk(1'b0, 1'b1, chan, data);
            n_acc   = 3'd4;
          end else begin
            acc[0] = mk(1'b0, 1'b1, chan, 8'd7);
            acc[1] = mk(1'b0, 1'b1, chan, data);
            n_acc  = 3'd2;
          end
        end else if (idx < IDX_OPT) begin
          sw_en  = 1'b1;
          acc[0] = mk(1'b0, 1'b1, chan, 8'(idx));
          acc[1] = mk(1'b0, 1'b1, chan, data);
          n_acc  = 3'd2;
          if (idx == 5'd9) begin
            sw_common = 1'b1; sw_val = data & 8'h3F;
          end else if (idx == 5'd14) begin
            sw_val = data & 8'h1F;
          end
        end else begin
          is_err = 1'b1;
        end
      end
      OP_READ: begin
        case (idx)
          5'd0: begin n_acc = 3'd1; acc[0] = mk(1'b0, 1'b0, chan, '0); end
          5'd8: begin n_acc = 3'd1; acc[0] = mk(1'b1, 1'b0, chan, '0); end
          5'd1, 5'd2, 5'd3, 5'd6, 5'd7, 5'd10: begin
            n_acc = 3'd2;
            acc[0] = mk(1'b0, 1'b1, (idx == 5'd2) ? 1'b1 : (idx == 5'd3) ? 1'b0 : chan, 8'(idx));
            acc[1] = mk(1'b0, 1'b0, (idx == 5'd2) ? 1'b1 : (idx == 5'd3) ? 1'b0 : chan, '0);
          end
          default: is_err = 1'b1;
        endcase
      end
      OP_SHADOW: begin
        if (idx == 5'd0 || idx == 5'd8 || idx > IDX_OPT) is_err = 1'b1;
        else is_local = 1'b1;
      end
      default: is_err = 1'b1;
    endcase
  end
endmodule

// File: rtl/regseq_top.sv
module regseq_top
  import regseq_pkg::*;
#(
  parameter int GAP_CLKS = 110
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [4:0]    req_idx,
  input  logic          req_chan,
  input  logic [7:0]    req_data,
  input  logic          req_nogap,
  output logic          busy,
  output logic          rsp_valid,
  output logic [7:0]    rsp_data,
  output logic          rsp_err,
  output logic          bus_stb,
  output logic          bus_sel_data,
  output logic          bus_wr,
  output logic          bus_chan,
  output logic [7:0]    bus_wdata,
  input  logic [7:0]    bus_rdata
);
  localparam int CNTW = $clog2(GAP_CLKS + 1);

  logic              rb_common, is_local, is_err, sw_en, sw_common, s15_en;
  logic [3:0]        rb_slot, sw_slot;
  logic [2:0]        n_acc;
  acc_t [MAXACC-1:0] acc;
  logic [DW-1:0]     lval, sw_val, s15_val, copy_val, sel_q;
  logic              accept;

  logic              active;
  logic [2:0]        step, n_q;
  acc_t [MAXACC-1:0] acc_q;
  logic [CNTW-1:0]   wait_cnt;
  logic              nogap_q;

  assign accept = req_valid && !active;

  regseq_shadow #(.NCH(2), .NREG(NREG), .DW(DW), .SEL_SLOT(15)) u_copy (
    .clk(clk), .rst(rst),
    .we(accept && sw_en && !is_err), .we_common(sw_common), .wchan(req_chan),
    .wslot(sw_slot), .wdata(sw_val),
    .we_sel(accept && s15_en && !is_err), .wsel_data(s15_val),
    .rchan(req_chan), .rslot(rb_slot), .rcommon(rb_common),
    .rdata(copy_val), .sel_q(sel_q)
  );

  regseq_decode u_dec (
    .op(req_op), .idx(req_idx), .chan(req_chan), .data(req_data),
    .sel_q(sel_q), .copy_val(copy_val),
    .rb_common(rb_common), .rb_slot(rb_slot),
    .n_acc(n_acc), .acc(acc), .is_local(is_local), .is_err(is_err), .lval(lval),
    .sw_en(sw_en), .sw_common(sw_common), .sw_slot(sw_slot), .sw_val(sw_val),
    .s15_en(s15_en), .s15_val(s15_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0; step <= '0; n_q <= '0; acc_q <= '0;
      wait_cnt <= '0; nogap_q <= 1'b0;
      rsp_valid <= 1'b0; rsp_err <= 1'b0; rsp_data <= '0;
      bus_stb <= 1'b0; bus_sel_data <= 1'b0; bus_wr <= 1'b0;
      bus_chan <= 1'b0; bus_wdata <= '0;
    end else begin
      bus_stb   <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      if (bus_stb && !bus_wr) rsp_data <= bus_rdata;
      if (!active) begin
        if (req_valid) begin
          if (is_err) begin
            rsp_err <= 1'b1;
          end else if (is_local) begin
            rsp_valid <= 1'b1;
            rsp_data  <= lval;
          end else begin
            active   <= 1'b1;
            acc_q    <= acc;
            n_q      <= n_acc;
            step     <= '0;
            wait_cnt <= '0;
            nogap_q  <= req_nogap;
            rsp_data <= '0;
          end
        end
      end else if (wait_cnt != '0) begin
        wait_cnt <= wait_cnt - 1'b1;
      end else if (step != n_q) begin
        bus_stb      <= 1'b1;
        bus_sel_data <= acc_q[step[1:0]].sel_data;
        bus_wr       <= acc_q[step[1:0]].wr;
        bus_chan     <= acc_q[step[1:0]].chan;
        bus_wdata    <= acc_q[step[1:0]].val;
        step         <= step + 1'b1;
        wait_cnt     <= ((step + 1'b1 == n_q) && nogap_q) ? '0 : CNTW'(GAP_CLKS);
      end else begin
        active    <= 1'b0;
        rsp_valid <= 1'b1;
      end
    end
  end

  assign busy = active;
endmodule

// File: rtl/regseq_chk.sv
module regseq_chk #(
  parameter int GAP_CLKS = 110
) (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic       rsp_valid,
  input logic       rsp_err,
  input logic       bus_stb
);
  logic [15:0] since;
  logic        seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      since <= '0; seen <= 1'b0;
    end else begin
      since <= bus_stb ? 16'd0 : (since == 16'hFFFF ? since : since + 1'b1);
      if (rsp_valid || rsp_err) seen <= 1'b0;
      else if (bus_stb) seen <= 1'b1;
    end
  end

  a_r1_gap: assert property (@(posedge clk) disable iff (rst)
    (bus_stb && seen) |-> (since == 16'(GAP_CLKS)));
  a_r9_stb_busy: assert property (@(posedge clk) disable iff (rst)
    bus_stb |-> busy);
  a_r9_rsp_idle: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !busy && !bus_stb);
  a_r10_err_quiet: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> !bus_stb && !busy && !rsp_valid);
  a_r11_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !busy && !bus_stb && !rsp_valid && !rsp_err);
endmodule

bind regseq_top regseq_chk #(.GAP_CLKS(GAP_CLKS)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .rsp_valid(rsp_valid),
  .rsp_err(rsp_err), .bus_stb(bus_stb)
);

// File: tb/sim_regseq_top.sv
module sim_regseq_top;
  localparam int GAP = 6;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_chan = 1'b0, req_nogap = 1'b0;
  logic [1:0] req_op = '0;
  logic [4:0] req_idx = '0;
  logic [7:0] req_data = '0;
  logic busy, rsp_valid, rsp_err, bus_stb, bus_sel_data, bus_wr, bus_chan;
  logic [7:0] rsp_data, bus_wdata, bus_rdata;
  logic [5:0] pulses = '0;

  int nchk = 0, nerr = 0;
  logic [7:0] bsh [2][16];
  logic [7:0] bcom;
  int exp_n, exp_kind;
  logic [10:0] exp_acc [4];
  logic [7:0] exp_lval;

  always #2 clk = ~clk;
  always @(posedge clk) if (bus_stb) pulses <= pulses + 1'b1;
  assign bus_rdata = {bus_chan, bus_sel_data, pulses};

  regseq_top #(.GAP_CLKS(GAP)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op), .req_idx(req_idx),
    .req_chan(req_chan), .req_data(req_data), .req_nogap(req_nogap),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .bus_stb(bus_stb), .bus_sel_data(bus_sel_data), .bus_wr(bus_wr),
    .bus_chan(bus_chan), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  initial begin
    #3000000;
    nerr++; nchk++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [10:0] a(bit sd, bit w, bit c, logic [7:0] v);
    return {sd, w, c, v};
  endfunction

  // Builds the expected outcome from the requirements and updates the copy model.
  task automatic model(input int op, input int idx, input bit ch, input logic [7:0] d);
    exp_n = 0; exp_kind = 0; exp_lval = '0;
    if (op == 0) begin
      if (idx == 0) begin exp_n = 1; exp_acc[0] = a(0,1,ch,d); end
      else if (idx == 8) begin exp_n = 1; exp_acc[0] = a(1,1,ch,d); end
      else if (idx == 7 || idx == 16) begin
        bit want = (idx == 16);
        if (bsh[ch][15][0] != want) begin
          bsh[ch][15][0] = want;
          exp_acc[0] = a(0,1,ch,8'd15); exp_acc[1] = a(0,1,ch,bsh[ch][15]);
          exp_acc[2] = a(0,1,ch,8'd7);  exp_acc[3] = a(0,1,ch,d); exp_n = 4;
        end else begin
          exp_acc[0] = a(0,1,ch,8'd7); exp_acc[1] = a(0,1,ch,d); exp_n = 2;
        end
        if (idx == 16) bsh[ch][8] = d; else bsh[ch][7] = d;
      end else if (idx < 16) begin
        exp_acc[0] = a(0,1,ch,8'(idx)); exp_acc[1] = a(0,1,ch,d); exp_n = 2;
        if (idx == 9) bcom = d & 8'h3F;
        else if (idx == 14) bsh[ch][14] = d & 8'h1F;
        else bsh[ch][idx] = d;
      end else exp_kind = 2;
    end else if (op == 1) begin
      if (idx == 0) begin exp_n = 1; exp_acc[0] = a(0,0,ch,0); end
      else if (idx == 8) begin exp_n = 1; exp_acc[0] = a(1,0,ch,0); end
      else if (idx inside {1,2,3,6,7,10}) begin
        bit c = (idx == 2) ? 1'b1 : (idx == 3) ? 1'b0 : ch;
        exp_n = 2; exp_acc[0] = a(0,1,c,8'(idx)); exp_acc[1] = a(0,0,c,0);
      end else exp_kind = 2;
    end else if (op == 2) begin
      if (idx == 0 || idx == 8 || idx > 16) exp_kind = 2;
      else begin
        exp_kind = 1;
        exp_lval = (idx == 9) ? bcom : (idx == 16) ? bsh[ch][8] : bsh[ch][idx];
      end
    end else exp_kind = 2;
  endtask

  task automatic do_req(input int op, input int idx, input bit ch, input logic [7:0] d,
                        input bit ng, input string tag);
    logic [10:0] log_a [8];
    int log_c [8];
    int n = 0, cyc = 0, done_c = 0;
    logic [7:0] seen_rd = '0;
    bit got_v = 0, got_e = 0;
    model(op, idx, ch, d);
    @(negedge clk);
    req_valid = 1; req_op = 2'(op); req_idx = 5'(idx); req_chan = ch;
    req_data = d; req_nogap = ng;
    @(negedge clk);
    req_valid = 0;
    for (int t = 0; t < 500; t++) begin
      cyc++;
      if (bus_stb && n < 8) begin
        log_a[n] = {bus_sel_data, bus_wr, bus_chan, bus_wr ? bus_wdata : 8'h00};
        log_c[n] = cyc; n++;
        if (!bus_wr) seen_rd = bus_rdata;
      end
      if (rsp_valid || rsp_err) begin got_v = rsp_valid; got_e = rsp_err; done_c = cyc; break; end
      @(negedge clk);
    end
    if (exp_kind == 2) begin
      check(got_e && n == 0, "R10 error pulse without bus cycle", n, 0);
      @(negedge clk);
      check(!rsp_err, "R10 error lasts one cycle", rsp_err, 0);
    end else if (exp_kind == 1) begin
      check(got_v && n == 0 && done_c == 1, {tag, " local answer timing"}, done_c, 1);
      check(rsp_data == exp_lval, {tag, " copy value"}, rsp_data, exp_lval);
    end else begin
      check(got_v && n == exp_n, {tag, " access count"}, n, exp_n);
      for (int k = 0; k < exp_n && k < n; k++)
        check(log_a[k] == exp_acc[k], {tag, " access content"}, log_a[k], exp_acc[k]);
      for (int k = 1; k < n; k++)
        check(log_c[k] - log_c[k-1] == GAP + 1, "R1 gap between strobes",
              log_c[k] - log_c[k-1], GAP + 1);
      if (n > 0) begin
        check(done_c - log_c[n-1] == (ng ? 1 : GAP + 1), "R9 completion delay",
              done_c - log_c[n-1], ng ? 1 : GAP + 1);
        if (!log_a[n-1][9])
          check(rsp_data == seen_rd, "R2 read data returned", rsp_data, seen_rd);
      end
    end
  endtask

  initial begin
    for (int c = 0; c < 2; c++) for (int r = 0; r < 16; r++) bsh[c][r] = '0;
    bcom = '0;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(!busy && !bus_stb && !rsp_valid && !rsp_err, "R11 idle after reset",
          {busy, bus_stb, rsp_valid, rsp_err}, 0);
    do_req(2, 5, 0, 0, 0, "R11");
    do_req(2, 15, 1, 0, 0, "R11");
    do_req(0, 5, 0, 8'h3C, 0, "R2");
    do_req(2, 5, 0, 0, 0, "R7");
    do_req(2, 5, 1, 0, 0, "R7");
    do_req(0, 5, 1, 8'hA5, 1, "R2");
    do_req(2, 5, 1, 0, 0, "R7");
    do_req(0, 0, 0, 8'h10, 0, "R3");
    do_req(1, 0, 1, 0, 0, "R3");
    do_req(0, 8, 1, 8'h77, 0, "R3");
    do_req(1, 8, 0, 0, 1, "R3");
    do_req(0, 16, 0, 8'h55, 0, "R5");
    do_req(2, 16, 0, 0, 0, "R5");
    do_req(2, 15, 0, 0, 0, "R5");
    do_req(0, 16, 0, 8'h66, 0, "R5");
    do_req(0, 7, 0, 8'h12, 0, "R4");
    do_req(0, 7, 0, 8'h13, 1, "R4");
    do_req(2, 7, 0, 0, 0, "R4");
    do_req(0, 15, 1, 8'hFF, 0, "R2");
    do_req(0, 7, 1, 8'h44, 0, "R4");
    do_req(2, 15, 1, 0, 0, "R4");
    do_req(0, 9, 1, 8'hFF, 0, "R6");
    do_req(2, 9, 0, 0, 0, "R6");
    do_req(0, 14, 0, 8'hE7, 0, "R6");
    do_req(2, 14, 0, 0, 0, "R6");
    do_req(1, 3, 1, 0, 0, "R8");
    do_req(1, 2, 0, 0, 0, "R8");
    do_req(1, 1, 1, 0, 1, "R2");
    do_req(0, 20, 0, 8'h01, 0, "R10");
    do_req(2, 0, 0, 0, 0, "R10");
    do_req(2, 8, 1, 0, 0, "R10");
    do_req(1, 5, 0, 0, 0, "R10");
    do_req(3, 1, 0, 0, 0, "R10");
    for (int i = 0; i < 160; i++)
      do_req($urandom % 4, $urandom % 18, 1'($urandom), 8'($urandom), 1'($urandom), "R2 random");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule